// File: doc/BRIEF.md
# Cascadable Serial Display Data Loader

This block is the serial front end of a four-digit multiplexed display. A host shifts a 20-bit frame into it one bit at a time. The frame holds a 4-bit decimal-point word followed by four 4-bit digit codes. When the host releases the active-low enable, the whole frame is copied into a holding latch. The latch drives the display, so the display never shows a half-shifted frame. A divide-by-four scanner walks the latched digits and presents one digit code, its decimal point and a one-hot strobe at a time.

All inputs are sampled in the block's own clock domain, and the block acts on edges of the sampled lines. The shift clock acts on its falling edge, the enable on its rising edge and the scan clock on its rising edge. A latched decimal-point word of all ones turns the decimal-point pin into the serial output of the last shift stage. Several devices can then be chained, and one long serial stream feeds every device in the chain.

Top module: `serial_digit_loader`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the latch and the scan counter. After reset `digitCodes` and `dpFlags` are zero, `digitSel` is 0001, and `dpOut` is 0.
- R2: The shift register moves one place and takes in `serIn` only on a falling edge of `shiftClk` seen while `enN` is low. The newest bit enters stage 0.
- R3: The bits of a 20-bit frame are taken in this order: the decimal-point word, digit 0, digit 1, digit 2 and digit 3, each most significant bit first. Digit i appears on `digitCodes[4i+3:4i]`. The first decimal-point bit shifted in appears on `dpFlags[3]`, and `dpFlags[i]` belongs to digit i.
- R4: The latch is loaded from the shift register only on a rising edge of `enN`. While shifting is in progress the outputs keep the previously latched frame.
- R5: Falling edges of `shiftClk` while `enN` is high have no effect on the shift register.
- R6: A load of only 16 bits places all four digit codes correctly. The decimal-point word then takes the four bits that were last in the low stages of the shift register.
- R7: Each rising edge of `scanClk` advances the scan index by one, wrapping from 3 to 0. `digitSel` is always one-hot, and bit i is set when index i is selected.
- R8: `scanCode` equals the latched code of the selected digit.
- R9: When the latched decimal-point word is not 1111, `dpOut` equals the decimal-point bit of the selected digit.
- R10: When the latched decimal-point word is 1111, `dpOut` carries the last shift stage, regardless of the scan index. A bit shifted in therefore appears on `dpOut` 20 shifts later.
- R11: Latching a frame whose decimal-point word is not 1111 leaves cascade mode, and `dpOut` returns to decimal-point duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial data |
| shiftClk | input | 1 | Shift clock; acts on its falling edge |
| enN | input | 1 | Active-low shift enable; its rising edge loads the latch |
| scanClk | input | 1 | Scan clock; each rising edge advances the scanner |
| digitCodes | output | 16 | Latched codes, digit i in bits 4i+3..4i |
| dpFlags | output | 4 | Latched decimal-point word, bit i for digit i |
| digitSel | output | 4 | One-hot digit strobe |
| scanCode | output | 4 | Code of the strobed digit |
| dpOut | output | 1 | Decimal point of the strobed digit, or the last shift stage in cascade mode |

## Verification
Four behaviours are checked by assertions on every cycle:
- each shift strobe moves the register by one place and takes in the sampled data bit;
- the latch changes only on a load strobe;
- the digit strobe stays one-hot and rotates only on a scan step;
- `dpOut` follows the cascade rule or the selected decimal-point bit.

The frame bit order, the 16-pulse short load, the ignored shift edges with enable high, and the 20-shift delay through the cascade path depend on whole sequences. Only the bench scenarios show these, by comparing the ports with the expected frame.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic scanStep;
  } sdlStrobes_t;
endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        shiftClk,
  input  logic        enN,
  input  logic        scanClk,
  output sdlStrobes_t strobes
);
  logic shiftPrev, enPrev, scanPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftPrev <= 1'b0;
      enPrev    <= 1'b1;
      scanPrev  <= 1'b0;
    end else begin
      shiftPrev <= shiftClk;
      enPrev    <= enN;
      scanPrev  <= scanClk;
    end
  end

  always_comb begin
    strobes.shiftEn  = shiftPrev & ~shiftClk & ~enN;
    strobes.loadEn   = ~enPrev & enN;
    strobes.scanStep = ~scanPrev & scanClk;
  end

  // R2
  shift_edge_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |-> $past(shiftClk) && !shiftClk && !enN);

  // R4
  load_edge_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadEn |-> enN && !$past(enN));

  // R7
  scan_edge_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.scanStep |-> scanClk && !$past(scanClk));
endmodule

// File: rtl/sdl_datapath.sv
module sdl_datapath
  import sdl_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int CODE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       serIn,
  input  sdlStrobes_t                strobes,
  output logic [DIGITS*CODE_W-1:0]   digitCodes,
  output logic [DIGITS-1:0]          dpFlags,
  output logic [DIGITS-1:0]          digitSel,
  output logic [CODE_W-1:0]          scanCode,
  output logic                       dpOut
);
  localparam int DIGIT_BITS = DIGITS * CODE_W;
  localparam int FRAME_W    = DIGIT_BITS + DIGITS;
  localparam int CNT_W      = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DIGITS - 1);

  logic [FRAME_W-1:0] shiftReg, holdReg;
  logic [CNT_W-1:0]   scanIdx;
  logic               cascadeOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      holdReg  <= '0;
      scanIdx  <= '0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], serIn};
      if (strobes.loadEn)  holdReg  <= shiftReg;
      if (strobes.scanStep) scanIdx <= (scanIdx == LAST_IDX) ? '0 : scanIdx + 1'b1;
    end
  end

  // Digit 0 is shifted in first after the point word, so it sits highest.
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign digitCodes[i*CODE_W +: CODE_W] = holdReg[(DIGITS-1-i)*CODE_W +: CODE_W];
    assign digitSel[i] = (scanIdx == CNT_W'(i));
  end

  assign dpFlags   = holdReg[FRAME_W-1 -: DIGITS];
  assign cascadeOn = &dpFlags;

  always_comb begin
    scanCode = '0;
    for (int i = 0; i < DIGITS; i++)
      if (scanIdx == CNT_W'(i)) scanCode = digitCodes[i*CODE_W +: CODE_W];
  end

  assign dpOut = cascadeOn ? shiftReg[FRAME_W-1] : |(dpFlags & digitSel);

  // R2
  shift_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> shiftReg[0] == $past(serIn)
                        && shiftReg[FRAME_W-1:1] == $past(shiftReg[FRAME_W-2:0]));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadEn |=> $stable(holdReg));

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(digitSel) == 1);

  // R7
  scan_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.scanStep |=> digitSel == {$past(digitSel[DIGITS-2:0]), $past(digitSel[DIGITS-1])});

  // R7
  scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.scanStep |=> $stable(digitSel));

  // R10
  cascade_out_chk: assert property (@(posedge clk) disable iff (rst)
    (&dpFlags) |-> dpOut == shiftReg[FRAME_W-1]);

  // R9
  dp_select_chk: assert property (@(posedge clk) disable iff (rst)
    !(&dpFlags) |-> dpOut == |(dpFlags & digitSel));
endmodule

// File: rtl/serial_digit_loader.sv
module serial_digit_loader
  import sdl_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     serIn,
  input  logic                     shiftClk,
  input  logic                     enN,
  input  logic                     scanClk,
  output logic [DIGITS*CODE_W-1:0] digitCodes,
  output logic [DIGITS-1:0]        dpFlags,
  output logic [DIGITS-1:0]        digitSel,
  output logic [CODE_W-1:0]        scanCode,
  output logic                     dpOut
);
  sdlStrobes_t strobes;

  sdl_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shiftClk (shiftClk),
    .enN      (enN),
    .scanClk  (scanClk),
    .strobes  (strobes)
  );

  sdl_datapath #(.DIGITS(DIGITS), .CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .serIn      (serIn),
    .strobes    (strobes),
    .digitCodes (digitCodes),
    .dpFlags    (dpFlags),
    .digitSel   (digitSel),
    .scanCode   (scanCode),
    .dpOut      (dpOut)
  );
endmodule

// File: tb/sim_serial_digit_loader.sv
`timescale 1ns/1ps
module sim_serial_digit_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0, shiftClk = 1'b0, enN = 1'b1, scanClk = 1'b0;
  logic [15:0] digitCodes;
  logic [3:0]  dpFlags, digitSel, scanCode;
  logic        dpOut;

  int checks = 0, fails = 0, sIdx = 0;
  logic [19:0] mSr = '0;
  bit done = 0;

  // Frames as {point word, digit0, digit1, digit2, digit3}.
  localparam logic [19:0] VEC [4] = '{20'h0_1234, 20'h5_9A0F, 20'hA_7C36, 20'h3_E58B};

  always #2 clk = ~clk;

  serial_digit_loader u0 (
    .clk(clk), .rst(rst), .serIn(serIn), .shiftClk(shiftClk), .enN(enN),
    .scanClk(scanClk), .digitCodes(digitCodes), .dpFlags(dpFlags),
    .digitSel(digitSel), .scanCode(scanCode), .dpOut(dpOut)
  );

  function automatic logic [15:0] digitsOf(input logic [19:0] w);
    return {w[3:0], w[7:4], w[11:8], w[15:12]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); serIn = b; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0;
    @(negedge clk);
    if (!enN) mSr = {mSr[18:0], b};
  endtask

  task automatic startLoad();
    @(negedge clk); enN = 1'b0;
  endtask

  task automatic endLoad();
    @(negedge clk); enN = 1'b1;
    @(negedge clk);
  endtask

  task automatic scanPulse();
    @(negedge clk); scanClk = 1'b1;
    @(negedge clk); scanClk = 1'b0;
    sIdx = (sIdx + 1) % 4;
  endtask

  task automatic checkScan(input logic [19:0] w, input string req);
    logic [15:0] d;
    d = digitsOf(w);
    for (int k = 0; k < 4; k++) begin
      check("R7 digitSel", 32'(digitSel), 32'(4'b0001 << sIdx));
      check("R8 scanCode", 32'(scanCode), 32'(d[sIdx*4 +: 4]));
      check(req, 32'(dpOut), 32'(w[16 + sIdx]));
      scanPulse();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] prevW, nextW;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 digitCodes", 32'(digitCodes), 32'h0);
    check("R1 dpFlags", 32'(dpFlags), 32'h0);
    check("R1 digitSel", 32'(digitSel), 32'h1);
    check("R1 dpOut", 32'(dpOut), 32'h0);

    prevW = '0;
    foreach (VEC[v]) begin
      startLoad();
      for (int i = 19; i >= 10; i--) shiftBit(VEC[v][i]);
      // R4 latch holds the old frame mid-shift
      check("R4 hold digits", 32'(digitCodes), 32'(digitsOf(prevW)));
      check("R4 hold dp", 32'(dpFlags), 32'(prevW[19:16]));
      for (int i = 9; i >= 0; i--) shiftBit(VEC[v][i]);
      endLoad();
      // R2 R3 frame order and digit placement
      check("R3 digits", 32'(digitCodes), 32'(digitsOf(VEC[v])));
      check("R3 dpFlags", 32'(dpFlags), 32'(VEC[v][19:16]));
      checkScan(VEC[v], "R9 dpOut");
      prevW = VEC[v];
    end

    // R5 shift edges with enable high are ignored
    for (int i = 0; i < 20; i++) shiftBit(i[0]);
    startLoad();
    endLoad();
    check("R5 digits", 32'(digitCodes), 32'(digitsOf(prevW)));
    check("R5 dpFlags", 32'(dpFlags), 32'(prevW[19:16]));

    // R6 sixteen-pulse load
    startLoad();
    for (int i = 15; i >= 0; i--) shiftBit(nextW_bit(16'hC0DE, i));
    endLoad();
    check("R6 digits", 32'(digitCodes), 32'(digitsOf({prevW[3:0], 16'hC0DE})));
    check("R6 dpFlags", 32'(dpFlags), 32'(prevW[3:0]));
    check("R6 model", 32'(mSr), 32'({prevW[3:0], 16'hC0DE}));

    // R10 cascade mode
    startLoad();
    for (int i = 19; i >= 0; i--) shiftBit(nextW_bit20(20'hF_4321, i));
    endLoad();
    check("R10 dpOut enter", 32'(dpOut), 32'(mSr[19]));
    scanPulse();
    check("R10 dpOut scan", 32'(dpOut), 32'(mSr[19]));
    nextW = 20'h2_ABCD;
    startLoad();
    for (int i = 19; i >= 0; i--) begin
      shiftBit(nextW[i]);
      check("R10 dpOut stream", 32'(dpOut), 32'(mSr[19]));
    end
    check("R10 first bit out", 32'(dpOut), 32'(nextW[19]));
    check("R4 cascade hold", 32'(digitCodes), 32'(digitsOf(20'hF_4321)));
    endLoad();
    // R11 leaving cascade mode
    check("R11 dpFlags", 32'(dpFlags), 32'(nextW[19:16]));
    checkScan(nextW, "R11 dpOut");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic nextW_bit(input logic [15:0] w, input int i);
    return w[i];
  endfunction

  function automatic logic nextW_bit20(input logic [19:0] w, input int i);
    return w[i];
  endfunction
endmodule